// File: doc/BRIEF.md
# CAN receive message ring buffer

This block holds received CAN frames in a byte-wide circular store. Each frame is kept as a whole variable-length message. A frame offered on the write side carries an extended flag, a remote-request flag, a 4-bit length code, an identifier and up to eight data bytes. The block packs these into a header byte, two or four identifier bytes and the data bytes. It then writes them into the store at one byte per clock, while `busy` holds off the next frame. A frame that does not fit is dropped whole, and `overrun` pulses for one cycle.

The CPU side reads through a 13-byte window at offsets 16 to 28. The window is anchored at the first byte of the oldest stored message, so offset 16 always shows the header of the oldest message. A release pulse frees that message. The length to free is recomputed from the stored header, and the window moves to the next message. The byte count, message count and `full` outputs drive the neighbouring status logic. While the controller is held in reset mode, no frame is accepted. Leaving reset mode empties the store.

The write side is a three-state machine:
- `FS_IDLE` waits for a frame. On an offered frame it goes to `FS_FILL` if the message fits, or to `FS_DROP` if it does not.
- `FS_FILL` writes one byte per cycle. It returns to `FS_IDLE` after the last byte, or at once if reset mode is entered.
- `FS_DROP` lasts one cycle, signals the overrun and returns to `FS_IDLE`.

Top module: `can_rx_ring`

## Requirements
- R1: The header byte, read at window offset 16, holds the extended flag in bit 7 and the remote-request flag in bit 6. Bits 5:4 are zero and bits 3:0 hold the raw length code.
- R2: An extended frame stores identifier bits 28..21 at offset 17, bits 20..13 at offset 18 and bits 12..5 at offset 19. Offset 20 carries bits 4..0 in its bits 7:3, with zeros below. Data byte k, taken from `frm_data[8k+7:8k]`, appears at offset 21+k.
- R3: A standard frame stores identifier bits 10..3 at offset 17. Offset 18 carries bits 2..0 in its bits 7:5, with zeros below. Data byte k appears at offset 19+k.
- R4: A stored message takes 3 bytes, plus 2 if extended, plus min(length code, 8) data bytes unless the frame is a remote request. `byte_count` grows by exactly that amount and `msg_count` by one. `byte_count` never exceeds the capacity.
- R5: A frame whose length added to `byte_count` would exceed the 64-byte capacity is discarded whole. `overrun` is then high for exactly one cycle, and both counts and the window are unchanged.
- R6: A release pulse with at least one message stored moves the window start forward by the oldest message's length. It also lowers `byte_count` by that length and `msg_count` by one.
- R7: A release pulse while `msg_count` is zero leaves both counts and the window contents unchanged.
- R8: Window offsets 16..28 return the byte at (start + offset − 16) modulo 64, wrapping across the end of the store. Every other offset reads 0.
- R9: While `reset_mode` is high, offered frames are not stored and `busy` stays low. The cycle after `reset_mode` falls, both counts and the window start return to zero.
- R10: After a frame is accepted, `busy` is high for exactly as many cycles as the message has bytes. A frame offered while `busy` is high is ignored.
- R11: `full` is high exactly when `byte_count` equals the capacity.
- R12: After `rst_n` is released, both counts are zero and `busy`, `overrun` and `full` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_mode | input | 1 | Controller held in reset mode |
| frm_valid | input | 1 | Frame offered this cycle |
| frm_ext | input | 1 | Extended (29-bit) identifier |
| frm_rtr | input | 1 | Remote request, no data stored |
| frm_dlc | input | 4 | Raw data length code |
| frm_id | input | 29 | Identifier, right-aligned |
| frm_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| busy | output | 1 | A message is being written or dropped |
| overrun | output | 1 | One-cycle pulse for a discarded frame |
| rel_req | input | 1 | Release the oldest message |
| win_off | input | 5 | Window read offset |
| win_data | output | 8 | Byte at the window offset |
| msg_count | output | 7 | Messages stored |
| byte_count | output | 7 | Bytes in use |
| full | output | 1 | Store completely occupied |

## Verification
The bench builds the block with its default 64-byte store. This keeps overrun and exact-full cases within a handful of frames, for example four 13-byte messages and one 12-byte message. The vector table is walked twice, so the window start passes the end of the store and wrapped messages are read and released. Running 7-bit counters against a small capacity also exercises the boundary between "fits exactly" and "discarded whole".

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;

    localparam int MSG_MAX  = 13;
    localparam int DATA_MAX = 8;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_FILL = 2'd1,
        FS_DROP = 2'd2
    } fill_state_e;

    // Stored message length from a header byte; release and store both use it.
    function automatic logic [3:0] msg_len(input logic [7:0] hdr);
        logic [3:0] nd;
        if (hdr[6])
            nd = 4'd0;
        else if (hdr[3:0] > 4'd8)
            nd = 4'd8;
        else
            nd = hdr[3:0];
        return 4'd3 + (hdr[7] ? 4'd2 : 4'd0) + nd;
    endfunction

endpackage

// File: rtl/can_rx_packer.sv
module can_rx_packer
    import can_rx_pkg::*;
(
    input  logic                          ext,
    input  logic                          rtr,
    input  logic [3:0]                    dlc,
    input  logic [28:0]                   id,
    input  logic [63:0]                   data,
    output logic [MSG_MAX-1:0][7:0]       img,
    output logic [3:0]                    len
);

    always_comb begin
        img    = '0;
        img[0] = {ext, rtr, 2'b00, dlc};
        if (ext) begin
            img[1] = id[28:21];
            img[2] = id[20:13];
            img[3] = id[12:5];
            img[4] = {id[4:0], 3'b000};
            for (int k = 0; k < DATA_MAX; k++)
                img[5+k] = data[8*k +: 8];
        end else begin
            img[1] = id[10:3];
            img[2] = {id[2:0], 5'b00000};
            for (int k = 0; k < DATA_MAX; k++)
                img[3+k] = data[8*k +: 8];
        end
    end

    assign len = msg_len(img[0]);

endmodule

// File: rtl/can_rx_mem.sv
module can_rx_mem #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/can_rx_fill.sv
module can_rx_fill
    import can_rx_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    offer,
    input  logic                    abort,
    input  logic                    clr,
    input  logic                    room_ok,
    input  logic [3:0]              len_in,
    input  logic [MSG_MAX-1:0][7:0] img_in,
    output logic                    busy,
    output logic                    overrun,
    output logic                    wr_en,
    output logic [AW-1:0]           wr_addr,
    output logic [7:0]              wr_data,
    output logic                    commit,
    output logic [3:0]              commit_len
);

    fill_state_e              state, nxt;
    logic [MSG_MAX-1:0][7:0]  cap;
    logic [3:0]               cap_len;
    logic [3:0]               idx;
    logic [AW-1:0]            wr_ptr;
    logic                     last;

    assign last = (idx == cap_len - 4'd1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= FS_IDLE;
        else
            state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            FS_IDLE: if (offer) nxt = room_ok ? FS_FILL : FS_DROP;
            FS_FILL: if (abort || last) nxt = FS_IDLE;
            FS_DROP: nxt = FS_IDLE;
            default: nxt = FS_IDLE;
        endcase
    end

    // Captured message, byte index and write pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap     <= '0;
            cap_len <= 4'd0;
            idx     <= 4'd0;
            wr_ptr  <= '0;
        end else begin
            if (state == FS_IDLE && offer && room_ok) begin
                cap     <= img_in;
                cap_len <= len_in;
                idx     <= 4'd0;
            end else if (state == FS_FILL) begin
                idx <= idx + 4'd1;
            end
            if (clr)
                wr_ptr <= '0;
            else if (commit)
                wr_ptr <= wr_ptr + AW'(cap_len);
        end
    end

    // Outputs
    always_comb begin
        busy       = (state != FS_IDLE);
        overrun    = (state == FS_DROP);
        wr_en      = (state == FS_FILL) && !abort;
        wr_addr    = wr_ptr + AW'(idx);
        wr_data    = cap[idx];
        commit     = (state == FS_FILL) && !abort && last;
        commit_len = cap_len;
    end

    // R9
    reset_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && state == FS_IDLE) |=> (state == FS_IDLE));

    // R5
    drop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> !overrun);

    // R10
    fill_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_FILL && !abort && !last) |=>
            (state == FS_FILL && idx == $past(idx) + 4'd1));

endmodule

// File: rtl/can_rx_ring.sv
module can_rx_ring
    import can_rx_pkg::*;
#(
    parameter int DEPTH     = 64,
    localparam int AW       = $clog2(DEPTH),
    localparam int CW       = AW + 1,
    localparam int WIN_BASE = 16,
    localparam int WIN_LAST = WIN_BASE + MSG_MAX - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reset_mode,
    input  logic          frm_valid,
    input  logic          frm_ext,
    input  logic          frm_rtr,
    input  logic [3:0]    frm_dlc,
    input  logic [28:0]   frm_id,
    input  logic [63:0]   frm_data,
    output logic          busy,
    output logic          overrun,
    input  logic          rel_req,
    input  logic [4:0]    win_off,
    output logic [7:0]    win_data,
    output logic [CW-1:0] msg_count,
    output logic [CW-1:0] byte_count,
    output logic          full
);

    logic [MSG_MAX-1:0][7:0] img;
    logic [3:0]              new_len;
    logic                    room_ok;
    logic                    mode_q;
    logic                    clr;
    logic                    wr_en;
    logic [AW-1:0]           wr_addr;
    logic [7:0]              wr_data;
    logic                    commit;
    logic [3:0]              commit_len;
    logic [AW-1:0]           rd_start;
    logic [AW-1:0]           win_addr;
    logic [7:0]              win_raw;
    logic [7:0]              hdr;
    logic                    rel_ok;
    logic [3:0]              rel_len;
    logic                    off_ok;

    can_rx_packer u_pack (
        .ext  (frm_ext),
        .rtr  (frm_rtr),
        .dlc  (frm_dlc),
        .id   (frm_id),
        .data (frm_data),
        .img  (img),
        .len  (new_len)
    );

    assign room_ok = ({1'b0, byte_count} + (CW+1)'(new_len)) <= (CW+1)'(DEPTH);

    can_rx_fill #(.AW(AW)) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .offer      (frm_valid && !reset_mode),
        .abort      (reset_mode),
        .clr        (clr),
        .room_ok    (room_ok),
        .len_in     (new_len),
        .img_in     (img),
        .busy       (busy),
        .overrun    (overrun),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .commit     (commit),
        .commit_len (commit_len)
    );

    can_rx_mem #(.DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .we      (wr_en),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .raddr_a (win_addr),
        .rdata_a (win_raw),
        .raddr_b (rd_start),
        .rdata_b (hdr)
    );

    // Leaving reset mode empties the store
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= 1'b1;
        else
            mode_q <= reset_mode;
    end
    assign clr = mode_q && !reset_mode;

    assign rel_ok  = rel_req && (msg_count != '0);
    assign rel_len = msg_len(hdr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_count <= '0;
            msg_count  <= '0;
            rd_start   <= '0;
        end else if (clr) begin
            byte_count <= '0;
            msg_count  <= '0;
            rd_start   <= '0;
        end else begin
            byte_count <= byte_count
                        + (commit ? CW'(commit_len) : CW'(0))
                        - (rel_ok ? CW'(rel_len)    : CW'(0));
            msg_count  <= msg_count
                        + (commit ? CW'(1) : CW'(0))
                        - (rel_ok ? CW'(1) : CW'(0));
            if (rel_ok)
                rd_start <= rd_start + AW'(rel_len);
        end
    end

    assign off_ok   = (int'(win_off) >= WIN_BASE) && (int'(win_off) <= WIN_LAST);
    assign win_addr = rd_start + AW'(win_off - 5'(WIN_BASE));
    assign win_data = off_ok ? win_raw : 8'h00;
    assign full     = (byte_count == CW'(DEPTH));

    // R4
    bytes_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_count <= CW'(DEPTH));

    // R7
    empty_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_req && msg_count == '0 && !commit && !clr) |=>
            ($stable(byte_count) && $stable(msg_count) && $stable(rd_start)));

    // R6
    release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_ok && !commit && !clr) |=> (msg_count == $past(msg_count) - CW'(1)));

    // R11
    full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (msg_count != '0));

endmodule

// File: tb/tb_can_rx_ring.sv
`timescale 1ns/1ps
module tb_can_rx_ring;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reset_mode = 1'b0;
    logic        frm_valid = 1'b0;
    logic        frm_ext = 1'b0;
    logic        frm_rtr = 1'b0;
    logic [3:0]  frm_dlc = 4'd0;
    logic [28:0] frm_id = '0;
    logic [63:0] frm_data = '0;
    logic        busy, overrun, full;
    logic        rel_req = 1'b0;
    logic [4:0]  win_off = 5'd16;
    logic [7:0]  win_data;
    logic [6:0]  msg_count, byte_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    can_rx_ring dut (
        .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode),
        .frm_valid(frm_valid), .frm_ext(frm_ext), .frm_rtr(frm_rtr),
        .frm_dlc(frm_dlc), .frm_id(frm_id), .frm_data(frm_data),
        .busy(busy), .overrun(overrun), .rel_req(rel_req),
        .win_off(win_off), .win_data(win_data),
        .msg_count(msg_count), .byte_count(byte_count), .full(full)
    );

    typedef struct packed {
        logic        ext;
        logic        rtr;
        logic [3:0]  dlc;
        logic [28:0] id;
        logic [63:0] data;
        logic [3:0]  len;
        logic [39:0] img;   // expected bytes at offsets 16..20
    } vec_t;

    localparam vec_t VT [7] = '{
        '{1'b0, 1'b0, 4'd2,  29'h123,      64'hBBAA,             4'd5,  40'h02_24_60_AA_BB},
        '{1'b1, 1'b0, 4'd8,  29'h1ABCDEF5, 64'h8877665544332211, 4'd13, 40'h88_D5_E6_F7_A8},
        '{1'b0, 1'b1, 4'd4,  29'h7FF,      64'hDEADBEEF,         4'd3,  40'h44_FF_E0_00_00},
        '{1'b1, 1'b1, 4'd3,  29'h1,        64'h0,                4'd5,  40'hC3_00_00_00_08},
        '{1'b0, 1'b0, 4'd12, 29'h1,        64'h0807060504030201, 4'd11, 40'h0C_00_20_01_02},
        '{1'b0, 1'b0, 4'd0,  29'h400,      64'h0,                4'd3,  40'h00_80_00_00_00},
        '{1'b1, 1'b0, 4'd1,  29'h1FFFFFFF, 64'h5A,               4'd6,  40'h81_FF_FF_FF_F8}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic send(input logic e, input logic r, input logic [3:0] d,
                        input logic [28:0] i, input logic [63:0] dat,
                        output int ncyc, output bit ov);
        @(negedge clk);
        frm_ext = e; frm_rtr = r; frm_dlc = d; frm_id = i; frm_data = dat;
        frm_valid = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
        ov = overrun;
        ncyc = 0;
        while (busy) begin
            ncyc++;
            @(negedge clk);
        end
    endtask

    task automatic rd(input int off, output int v);
        win_off = 5'(off);
        #1;
        v = int'(win_data);
    endtask

    task automatic release_one();
        @(negedge clk);
        rel_req = 1'b1;
        @(negedge clk);
        rel_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        int n, v, v0, nchk;
        bit ov;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12", "msg_count", int'(msg_count), 0);
        chk("R12", "byte_count", int'(byte_count), 0);
        chk("R12", "busy", int'(busy), 0);
        chk("R12", "overrun", int'(overrun), 0);
        chk("R12", "full", int'(full), 0);

        // Table walk, twice so the window start wraps past the end (R8)
        for (int pass = 0; pass < 2; pass++) begin
            for (int k = 0; k < 7; k++) begin
                send(VT[k].ext, VT[k].rtr, VT[k].dlc, VT[k].id, VT[k].data, n, ov);
                chk("R10", "busy cycles", n, int'(VT[k].len));
                chk("R4", "byte_count", int'(byte_count), int'(VT[k].len));
                chk("R4", "msg_count", int'(msg_count), 1);
                nchk = (VT[k].len < 5) ? int'(VT[k].len) : 5;
                for (int b = 0; b < nchk; b++) begin
                    rd(16 + b, v);
                    if (b == 0)
                        chk("R1", "header", v, int'(VT[k].img[39 -: 8]));
                    else if (VT[k].ext)
                        chk("R2", "ext byte", v, int'(VT[k].img[39-8*b -: 8]));
                    else
                        chk("R3", "std byte", v, int'(VT[k].img[39-8*b -: 8]));
                end
                release_one();
                chk("R6", "byte_count after release", int'(byte_count), 0);
                chk("R6", "msg_count after release", int'(msg_count), 0);
            end
        end
        // window start now 92 mod 64 = 28

        // R7 release on empty
        rd(16, v0);
        release_one();
        chk("R7", "byte_count", int'(byte_count), 0);
        chk("R7", "msg_count", int'(msg_count), 0);
        rd(16, v);
        chk("R7", "window unchanged", v, v0);

        // R8 offsets outside the window read zero
        rd(0, v);  chk("R8", "offset 0", v, 0);
        rd(15, v); chk("R8", "offset 15", v, 0);
        rd(29, v); chk("R8", "offset 29", v, 0);
        rd(31, v); chk("R8", "offset 31", v, 0);

        // R10 frame offered while busy is ignored
        @(negedge clk);
        frm_ext = 1'b1; frm_rtr = 1'b0; frm_dlc = 4'd8; frm_id = 29'h55;
        frm_data = 64'h8877665544332211;
        frm_valid = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
        repeat (3) @(negedge clk);
        frm_ext = 1'b0; frm_dlc = 4'd0; frm_id = 29'h7;
        frm_valid = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R10", "msg_count with offer while busy", int'(msg_count), 1);
        chk("R10", "byte_count with offer while busy", int'(byte_count), 13);
        rd(16, v);
        chk("R10", "header of first frame", v, 8'h88);
        release_one();   // window start 41

        // R11 exact fill: 4 x 13 + 12 = 64
        for (int k = 0; k < 4; k++) begin
            send(1'b1, 1'b0, 4'd8, 29'h10 + 29'(k), 64'h8877665544332211, n, ov);
            chk("R11", "not full yet", int'(full), 0);
        end
        send(1'b1, 1'b0, 4'd7, 29'h20, 64'h77665544332211, n, ov);
        chk("R11", "full", int'(full), 1);
        chk("R11", "byte_count", int'(byte_count), 64);
        chk("R11", "msg_count", int'(msg_count), 5);

        // R5 overrun: 3 more bytes do not fit
        send(1'b0, 1'b0, 4'd0, 29'h1, 64'h0, n, ov);
        chk("R5", "overrun pulse", int'(ov), 1);
        chk("R5", "busy cycles on drop", n, 1);
        chk("R5", "overrun cleared", int'(overrun), 0);
        chk("R5", "byte_count kept", int'(byte_count), 64);
        chk("R5", "msg_count kept", int'(msg_count), 5);

        // R6 release from full
        release_one();
        chk("R6", "byte_count", int'(byte_count), 51);
        chk("R6", "msg_count", int'(msg_count), 4);
        chk("R11", "full cleared", int'(full), 0);
        release_one();   // start 54, message spans 54..66 and wraps
        rd(16, v);
        chk("R6", "next header", v, 8'h88);
        rd(28, v);
        chk("R8", "wrapped last data byte", v, 8'h88);

        // R9 reset mode refuses frames, leaving it clears counts
        @(negedge clk);
        reset_mode = 1'b1;
        send(1'b0, 1'b0, 4'd1, 29'h3, 64'h1, n, ov);
        chk("R9", "busy in reset mode", n, 0);
        chk("R9", "byte_count kept", int'(byte_count), 38);
        @(negedge clk);
        reset_mode = 1'b0;
        @(negedge clk);
        chk("R9", "byte_count cleared", int'(byte_count), 0);
        chk("R9", "msg_count cleared", int'(msg_count), 0);
        send(1'b0, 1'b0, 4'd2, 29'h123, 64'hBBAA, n, ov);
        rd(16, v);
        chk("R9", "header at restart", v, 8'h02);
        rd(17, v);
        chk("R9", "id byte at restart", v, 8'h24);
        chk("R9", "byte_count after restart", int'(byte_count), 5);

        done = 1'b1;
        report();
        $finish;
    end

endmodule